// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-visible register file of a single descriptor-driven DMA channel. Software drives the channel through one control word. A control write carries a bit mask in its upper half and new bit values in its lower half, so one 32-bit access can set some status bits and clear others while leaving the rest untouched. Each status bit has a fixed owner:

- RUN and PAUSE belong to software.
- FLUSH and WAKE are raised by software and dropped by hardware.
- DEAD, ACTIVE and BRANCH-TAKEN change only through sequencer events.

The block also holds the descriptor pointer and three condition-select words (interrupt, branch, wait) for the descriptor sequencer. After every control write it re-derives ACTIVE. It sends the sequencer a one-cycle kick when the channel is left active, and it sends the device side a one-cycle flush request when software asks for a flush or when the channel is stopped or paused.

Register offsets come from address bits 6:2, and only full 32-bit accesses exist. The layout is as follows:

| Offset | Register | Read | Write |
|---|---|---|---|
| 0 | control | returns the status word | masked update |
| 1 | status | status word | ignored |
| 3 | descriptor pointer | pointer | see R10 |
| 4 | interrupt select | stored word | stored |
| 5 | branch select | stored word | stored |
| 6 | wait select | stored word | stored |
| any other | unused | zero | no effect |

Status word layout:

| Bit | Field |
|---|---|
| 15 | RUN |
| 14 | PAUSE |
| 13 | FLUSH |
| 12 | WAKE |
| 11 | DEAD |
| 10 | ACTIVE |
| 8 | BRANCH-TAKEN |
| 3:0 | live device status input |

All other status bits read as zero.

Top module: `chreg_dma_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears: the status word reads 0, and the pointer and select words read 0. `chan_active`, `dev_flush` and `seq_kick` are low.
- R2: A control write (offset 0) changes only those of RUN, PAUSE and WAKE whose mask bit (write bit 16+n) is 1. The new value comes from write bit n. A write with an all-zero mask leaves RUN, PAUSE and WAKE unchanged.
- R3: A control write that leaves RUN=1 and PAUSE=0, and whose mask touches RUN or PAUSE, sets ACTIVE (bit 10). `seq_kick` is high for exactly the one cycle after every control write that leaves ACTIVE set.
- R4: A control write that clears RUN also clears DEAD.
- R5: Any control write that leaves PAUSE=1 or RUN=0 clears ACTIVE and raises `dev_flush` for one cycle. Clearing PAUSE with RUN=1 sets ACTIVE again.
- R6: Setting WAKE (bit 12) takes effect only while RUN is 1 after the write. When it takes effect it also sets ACTIVE. A `seq_fetch` pulse clears WAKE.
- R7: A control write with FLUSH (bit 13) masked and set raises `dev_flush` for one cycle. FLUSH reads as 1 in the status word during that same cycle and only then.
- R8: Control-write mask bits for DEAD, ACTIVE and BRANCH-TAKEN (bits 11, 10, 8) have no effect. A write to the status register (offset 1) has no effect.
- R9: A read of offset 0 or offset 1 returns the status word, with the field positions given above.
- R10: A write to the descriptor pointer (offset 3) is ignored while ACTIVE is 1. An accepted write stores the value with bits 3:0 cleared.
- R11: The select words at offsets 4, 5 and 6 store full 32-bit values and read them back, and they also drive their output ports. Every other offset reads as zero.
- R12: Sequencer events apply after the software update in the same cycle:
  - `seq_kill` sets DEAD and clears ACTIVE.
  - `seq_stop` clears ACTIVE.
  - `seq_bt_upd` loads BRANCH-TAKEN from `seq_bt_val`.
  - A control write in a cycle with `seq_stop` or `seq_kill` high therefore leaves ACTIVE clear and sends no kick.
- R13: Status bits 3:0 follow the `dev_stat` input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe (full 32-bit word) |
| reg_addr | input | 5 | Register offset, address bits 6:2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dev_stat | input | 4 | Device condition bits shown in status 3:0 |
| seq_fetch | input | 1 | Sequencer fetched a descriptor; clears WAKE |
| seq_stop | input | 1 | Sequencer hit a stop descriptor; clears ACTIVE |
| seq_kill | input | 1 | Sequencer found a fatal descriptor; sets DEAD, clears ACTIVE |
| seq_bt_upd | input | 1 | Load BRANCH-TAKEN |
| seq_bt_val | input | 1 | Value for BRANCH-TAKEN |
| chan_active | output | 1 | ACTIVE status bit |
| dev_flush | output | 1 | One-cycle flush request to the device side |
| seq_kick | output | 1 | One-cycle start pulse to the sequencer |
| cmd_ptr | output | 32 | Descriptor pointer, 16-byte aligned |
| intr_sel | output | 32 | Interrupt condition select word |
| branch_sel | output | 32 | Branch condition select word |
| wait_sel | output | 32 | Wait condition select word |

## Verification
A software control write and a sequencer event can land in the same cycle. The typical case is a write that sets RUN while the sequencer reports a stop or a kill. The bench provokes this by holding `seq_stop` high across the clock edge that takes a RUN-setting control write. It judges the result by requiring that RUN is set, ACTIVE stays clear and no kick follows. The bench also checks that a pointer write is refused in the cycle after a control write has activated the channel, and accepted once a stopping write has cleared ACTIVE.

// File: rtl/chreg_pkg.sv
// Package: shared bit positions, register offsets and the stored status
// type of the DMA channel register block.
// Assumes a 32-bit register word split into a 16-bit mask and 16-bit values.
package chreg_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned HALF_W   = DATA_W / 2;
    localparam int unsigned DEV_W    = 4;

    // Status / control bit positions (software decodes these).
    localparam int unsigned B_RUN    = 15;
    localparam int unsigned B_PAUSE  = 14;
    localparam int unsigned B_FLUSH  = 13;
    localparam int unsigned B_WAKE   = 12;
    localparam int unsigned B_DEAD   = 11;
    localparam int unsigned B_ACTIVE = 10;
    localparam int unsigned B_BT     = 8;

    // Register offsets in words (address bits 6:2).
    localparam int unsigned OFF_CTRL = 0;
    localparam int unsigned OFF_STAT = 1;
    localparam int unsigned OFF_PTR  = 3;
    localparam int unsigned OFF_SEL0 = 4;
    localparam int unsigned NUM_SEL  = 3;
    localparam int unsigned PTR_LSBS = 4;

    // Stored status flags; FLUSH is not stored, it is the flush pulse.
    typedef struct packed {
        logic run;
        logic pause;
        logic wake;
        logic dead;
        logic active;
        logic bt;
    } chst_t;

endpackage

// File: rtl/chreg_ctl_merge.sv
// Module: chreg_ctl_merge
// Computes the status that results from one masked control write, and
// whether that write requests a device flush. Purely combinational.
// Assumes: sequencer events are applied later by the caller.
module chreg_ctl_merge
    import chreg_pkg::*;
(
    input  chst_t               cur,
    input  logic [DATA_W-1:0]   wdata,
    output chst_t               nxt,
    output logic                flush_req
);

    logic [HALF_W-1:0] msk;
    logic [HALF_W-1:0] val;
    logic              unused_bits;

    assign msk = wdata[DATA_W-1:HALF_W];
    assign val = wdata[HALF_W-1:0];
    assign unused_bits = ^{msk[B_DEAD], msk[B_ACTIVE], msk[B_BT], val[B_DEAD],
                           val[B_ACTIVE], val[B_BT], msk[11:0], val[11:0]};

    // Apply software-owned bits, then re-derive ACTIVE and the flush need.
    always_comb begin
        nxt       = cur;
        flush_req = 1'b0;
        if (msk[B_RUN]) begin
            if (val[B_RUN]) begin
                nxt.run = 1'b1;
            end else begin
                nxt.run  = 1'b0;
                nxt.dead = 1'b0;
            end
        end
        if (msk[B_WAKE] && val[B_WAKE] && nxt.run) begin
            nxt.wake = 1'b1;
        end
        if (msk[B_PAUSE]) begin
            nxt.pause = val[B_PAUSE];
        end
        if (msk[B_FLUSH] && val[B_FLUSH]) begin
            flush_req = 1'b1;
        end
        if (nxt.pause || !nxt.run) begin
            nxt.active = 1'b0;
            flush_req  = 1'b1;
        end else if (msk[B_RUN] || msk[B_PAUSE]) begin
            nxt.active = 1'b1;
        end else if (msk[B_WAKE] && val[B_WAKE]) begin
            nxt.active = 1'b1;
        end
    end

endmodule

// File: rtl/chreg_status.sv
// Module: chreg_status
// Holds the stored status flags, merges software control writes with
// sequencer events (sequencer applied last), and registers the one-cycle
// flush and kick pulses.
// Assumes: synchronous active-low reset; one control write per cycle at most.
module chreg_status
    import chreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seq_fetch,
    input  logic              seq_stop,
    input  logic              seq_kill,
    input  logic              seq_bt_upd,
    input  logic              seq_bt_val,
    output chst_t             st,
    output logic              flush_o,
    output logic              kick_o
);

    chst_t st_q;
    chst_t st_sw;
    chst_t st_d;
    logic  sw_flush;

    chreg_ctl_merge u_merge (
        .cur       (st_q),
        .wdata     (wdata),
        .nxt       (st_sw),
        .flush_req (sw_flush)
    );

    // Next status: software update first, sequencer events override.
    always_comb begin
        st_d = ctrl_we ? st_sw : st_q;
        if (seq_fetch)  st_d.wake   = 1'b0;
        if (seq_stop)   st_d.active = 1'b0;
        if (seq_kill) begin
            st_d.dead   = 1'b1;
            st_d.active = 1'b0;
        end
        if (seq_bt_upd) st_d.bt     = seq_bt_val;
    end

    // Status flags and the flush/kick pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            flush_o <= 1'b0;
            kick_o  <= 1'b0;
        end else begin
            st_q    <= st_d;
            flush_o <= ctrl_we && sw_flush;
            kick_o  <= ctrl_we && st_d.active;
        end
    end

    assign st = st_q;

    p_active_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(ctrl_we));
    p_kick_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> st_q.active);
    p_run_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> (!st_q.dead && !st_q.active));
    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(ctrl_we));
    p_dead_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dead) |-> $past(seq_kill));

endmodule

// File: rtl/chreg_ptrsel.sv
// Module: chreg_ptrsel
// Holds the aligned descriptor pointer (write-locked while the channel is
// active) and the condition-select words, one generated register each.
// Assumes: offsets are word offsets; writes are full words.
module chreg_ptrsel
    import chreg_pkg::*;
#(
    parameter int unsigned OFF_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [OFF_W-1:0]           off,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       active,
    output logic [DATA_W-1:0]          ptr_o,
    output logic [NUM_SEL*DATA_W-1:0]  sel_o
);

    localparam logic [OFF_W-1:0] PTR_OFF = OFF_W'(OFF_PTR);

    logic [DATA_W-1:0] ptr_q;

    // Descriptor pointer: accepted only while inactive, low bits forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (we && off == PTR_OFF && !active) begin
            ptr_q <= {wdata[DATA_W-1:PTR_LSBS], {PTR_LSBS{1'b0}}};
        end
    end

    assign ptr_o = ptr_q;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(OFF_SEL0 + g);
        logic [DATA_W-1:0] sel_q;

        // One condition-select word, plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (we && off == MY_OFF) begin
                sel_q <= wdata;
            end
        end

        assign sel_o[g*DATA_W +: DATA_W] = sel_q;
    end

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> !$past(active));
    p_ptr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[PTR_LSBS-1:0] == '0);

endmodule

// File: rtl/chreg_dma_ctl.sv
// Module: chreg_dma_ctl (top)
// Register file of one DMA channel: decodes word offsets, routes control
// writes to the status logic, assembles the status word and the read mux.
// Assumes: full 32-bit accesses; offset from address bits 6:2.
module chreg_dma_ctl
    import chreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:2] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        dev_stat,
    input  logic              seq_fetch,
    input  logic              seq_stop,
    input  logic              seq_kill,
    input  logic              seq_bt_upd,
    input  logic              seq_bt_val,
    output logic              chan_active,
    output logic              dev_flush,
    output logic              seq_kick,
    output logic [31:0]       cmd_ptr,
    output logic [31:0]       intr_sel,
    output logic [31:0]       branch_sel,
    output logic [31:0]       wait_sel
);

    localparam int unsigned OFF_W = ADDR_W - 2;

    chst_t                      st;
    logic                       ctrl_we;
    logic [DATA_W-1:0]          stat_word;
    logic [NUM_SEL*DATA_W-1:0]  sel_flat;

    assign ctrl_we = reg_we && (reg_addr == OFF_W'(OFF_CTRL));

    chreg_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .wdata      (reg_wdata),
        .seq_fetch  (seq_fetch),
        .seq_stop   (seq_stop),
        .seq_kill   (seq_kill),
        .seq_bt_upd (seq_bt_upd),
        .seq_bt_val (seq_bt_val),
        .st         (st),
        .flush_o    (dev_flush),
        .kick_o     (seq_kick)
    );

    chreg_ptrsel #(.OFF_W(OFF_W)) u_ptrsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .off    (reg_addr),
        .wdata  (reg_wdata),
        .active (st.active),
        .ptr_o  (cmd_ptr),
        .sel_o  (sel_flat)
    );

    assign intr_sel    = sel_flat[0*DATA_W +: DATA_W];
    assign branch_sel  = sel_flat[1*DATA_W +: DATA_W];
    assign wait_sel    = sel_flat[2*DATA_W +: DATA_W];
    assign chan_active = st.active;

    // Assemble the software-visible status word.
    always_comb begin
        stat_word           = '0;
        stat_word[B_RUN]    = st.run;
        stat_word[B_PAUSE]  = st.pause;
        stat_word[B_FLUSH]  = dev_flush;
        stat_word[B_WAKE]   = st.wake;
        stat_word[B_DEAD]   = st.dead;
        stat_word[B_ACTIVE] = st.active;
        stat_word[B_BT]     = st.bt;
        stat_word[DEV_W-1:0] = dev_stat;
    end

    // Read mux by word offset; unused offsets return zero.
    always_comb begin
        if (reg_addr == OFF_W'(OFF_CTRL) || reg_addr == OFF_W'(OFF_STAT))
            reg_rdata = stat_word;
        else if (reg_addr == OFF_W'(OFF_PTR))
            reg_rdata = cmd_ptr;
        else if (reg_addr == OFF_W'(OFF_SEL0))
            reg_rdata = intr_sel;
        else if (reg_addr == OFF_W'(OFF_SEL0 + 1))
            reg_rdata = branch_sel;
        else if (reg_addr == OFF_W'(OFF_SEL0 + 2))
            reg_rdata = wait_sel;
        else
            reg_rdata = '0;
    end

    p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_flush |-> reg_rdata[B_FLUSH] || !(reg_addr == OFF_W'(OFF_CTRL)));

endmodule

// File: tb/chreg_dma_ctl_tb.sv
module chreg_dma_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  dev_stat = '0;
    logic        seq_fetch = 1'b0, seq_stop = 1'b0, seq_kill = 1'b0;
    logic        seq_bt_upd = 1'b0, seq_bt_val = 1'b0;
    logic        chan_active, dev_flush, seq_kick;
    logic [31:0] cmd_ptr, intr_sel, branch_sel, wait_sel;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    chreg_dma_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_stat(dev_stat),
        .seq_fetch(seq_fetch), .seq_stop(seq_stop), .seq_kill(seq_kill),
        .seq_bt_upd(seq_bt_upd), .seq_bt_val(seq_bt_val),
        .chan_active(chan_active), .dev_flush(dev_flush), .seq_kick(seq_kick),
        .cmd_ptr(cmd_ptr), .intr_sel(intr_sel), .branch_sel(branch_sel),
        .wait_sel(wait_sel)
    );

    // {control write word, expected status, expected flush, expected kick}
    localparam logic [49:0] VEC [10] = '{
        {32'h8000_8000, 16'h8400, 1'b0, 1'b1},  // R3 set RUN
        {32'h4000_4000, 16'hE000, 1'b1, 1'b0},  // R5 set PAUSE
        {32'h4000_0000, 16'h8400, 1'b0, 1'b1},  // R5 clear PAUSE
        {32'h2000_2000, 16'hA400, 1'b1, 1'b1},  // R7 FLUSH while active
        {32'h0D00_0D00, 16'h8400, 1'b0, 1'b1},  // R8 hw-owned bits ignored
        {32'h1000_1000, 16'h9400, 1'b0, 1'b1},  // R6 WAKE with RUN
        {32'h8000_0000, 16'h3000, 1'b1, 1'b0},  // R4 clear RUN
        {32'h1000_1000, 16'h3000, 1'b1, 1'b0},  // R6 WAKE without RUN
        {32'h0000_0000, 16'h3000, 1'b1, 1'b0},  // R2 empty mask
        {32'hC000_8000, 16'h9400, 1'b0, 1'b1}   // R2 set RUN + clear PAUSE
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [4:0] off, output logic [31:0] d);
        reg_addr = off;
        #1;
        d = reg_rdata;
        reg_addr = 5'd0;
        #1;
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    logic [31:0] r;

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 status after reset", reg_rdata, 32'h0);
        chk("R1 outputs after reset", {29'd0, chan_active, dev_flush, seq_kick}, 32'h0);
        rd(5'd3, r); chk("R1 pointer after reset", r, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            wr(5'd0, VEC[i][49:18]);
            chk($sformatf("R2-table vec%0d status", i), reg_rdata, {16'h0, VEC[i][17:2]});
            chk($sformatf("R5-table vec%0d flush", i), {31'd0, dev_flush}, {31'd0, VEC[i][1]});
            chk($sformatf("R3-table vec%0d kick", i), {31'd0, seq_kick}, {31'd0, VEC[i][0]});
        end
        tick;
        chk("R3 kick lasts one cycle", {31'd0, seq_kick}, 32'h0);
        chk("R7 FLUSH bit gone after pulse", reg_rdata, 32'h9400);

        @(negedge clk); seq_fetch = 1'b1; @(negedge clk); seq_fetch = 1'b0; #1;
        chk("R6 fetch clears WAKE", reg_rdata, 32'h8400);

        wr(5'd3, 32'h1234_5678);
        rd(5'd3, r); chk("R10 pointer locked while active", r, 32'h0);

        @(negedge clk); seq_bt_upd = 1'b1; seq_bt_val = 1'b1;
        @(negedge clk); seq_bt_upd = 1'b0; seq_bt_val = 1'b0; #1;
        chk("R12 branch-taken set", reg_rdata, 32'h8500);
        @(negedge clk); seq_bt_upd = 1'b1;
        @(negedge clk); seq_bt_upd = 1'b0; #1;
        chk("R12 branch-taken cleared", reg_rdata, 32'h8400);

        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, r); chk("R8 status write ignored", r, 32'h8400);

        dev_stat = 4'hA; #1;
        chk("R13 device bits visible", reg_rdata, 32'h840A);
        dev_stat = 4'h0; #1;

        @(negedge clk); seq_kill = 1'b1; @(negedge clk); seq_kill = 1'b0; #1;
        chk("R12 kill sets DEAD clears ACTIVE", reg_rdata, 32'h8800);
        chk("R12 chan_active low after kill", {31'd0, chan_active}, 32'h0);

        wr(5'd0, 32'h8000_0000);
        chk("R4 clearing RUN clears DEAD", reg_rdata, 32'h2000);
        chk("R4 stop raises flush", {31'd0, dev_flush}, 32'h1);

        wr(5'd3, 32'h1234_567F);
        rd(5'd3, r); chk("R10 pointer aligned", r, 32'h1234_5670);
        chk("R10 pointer port", cmd_ptr, 32'h1234_5670);

        wr(5'd4, 32'h000F_0005);
        wr(5'd5, 32'h0003_0001);
        wr(5'd6, 32'h000C_0008);
        rd(5'd4, r); chk("R11 interrupt select", r, 32'h000F_0005);
        rd(5'd5, r); chk("R11 branch select", r, 32'h0003_0001);
        rd(5'd6, r); chk("R11 wait select", r, 32'h000C_0008);
        chk("R11 select ports", intr_sel ^ branch_sel ^ wait_sel, 32'h0000_000C);
        rd(5'd2, r); chk("R11 offset 2 reads zero", r, 32'h0);
        rd(5'd7, r); chk("R11 offset 7 reads zero", r, 32'h0);
        rd(5'd31, r); chk("R11 offset 31 reads zero", r, 32'h0);
        rd(5'd0, r); chk("R9 control offset returns status", r, 32'h0);

        @(negedge clk);
        seq_stop = 1'b1; reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h8000_8000;
        @(negedge clk);
        seq_stop = 1'b0; reg_we = 1'b0; reg_wdata = '0; #1;
        chk("R12 same-cycle stop beats RUN write", reg_rdata, 32'h8000);
        chk("R12 no kick when stopped", {31'd0, seq_kick}, 32'h0);

        wr(5'd0, 32'h4000_0000);
        chk("R5 PAUSE touch reactivates", reg_rdata, 32'h8400);
        chk("R3 kick after reactivation", {31'd0, seq_kick}, 32'h1);
        wr(5'd3, 32'hAAAA_AAA0);
        rd(5'd3, r); chk("R10 locked after activation", r, 32'h1234_5670);
        @(negedge clk); seq_stop = 1'b1; @(negedge clk); seq_stop = 1'b0; #1;
        chk("R12 stop clears ACTIVE", reg_rdata, 32'h8000);

        @(negedge clk); rst_n = 1'b0; @(negedge clk); #1;
        chk("R1 status after late reset", reg_rdata, 32'h0);
        rd(5'd3, r); chk("R1 pointer after late reset", r, 32'h0);
        chk("R1 selects after late reset", intr_sel | branch_sel | wait_sel, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule